// File: doc/BRIEF.md
# Boot-Time Clock Configuration Sequencer

This block runs once after every reset and programs two serially controlled clock buffers before the processor may start. It hands a short list of single-byte register writes, one at a time, to an SPI master through a request/acknowledge/done handshake. The list selects the input source of the sampling-clock buffer and sets up that buffer's output 3 so that an 80 MHz LVDS clock reaches the FPGA. When an external PLL module is fitted, the list also sets the reference buffer's output 0 to divide by eight, which gives the PLL a 10 MHz reference. Each buffer's list closes with a commit write to its self-clearing update flag.

While the writes are in progress, `bootHold` keeps the processor in reset. After the final commit has completed, `bootHold` falls and `seqDone` rises, and both stay there until the next reset. The two option inputs are read once, on the first clock edge after reset is released. Later changes to them have no effect until the next reset.

Top module: `clk_boot_sequencer`

## Requirements
- R1: During reset `bootHold` is 1, and `seqDone` and `frameReq` are 0.
- R2: The first frame targets the sampling buffer (`frameSel` = 2'b01), address 0x45. Its data is 0x05 when `srcExternal` was 0 (on-board input: bit 0 set to select it, bit 2 set to power down the other input). Its data is 0x02 when `srcExternal` was 1 (bit 0 clear, bit 1 set to power down the on-board input).
- R3: Frames two to four go to the sampling buffer in this order: 0x40 <= 0x02 (output 3 on, LVDS type); 0x50 <= divider code; 0x51 <= divider control. For a ratio of 1 (the default `FPGA_DIV`) the code is 0x00 and the control is 0x80 (bypass). For an even ratio N the code holds N/2-1 in both [3:0] and [7:4], and the control is 0x00.
- R4: Each buffer's list ends with 0x01 written to address 0x5A.
- R5: When `pllPresent` was 1, four frames to the reference buffer (`frameSel` = 2'b10) follow the sampling list: 0x45 <= 0x05, 0x4A <= 0x33 (divide by `REF_DIV` = 8), 0x4B <= 0x00, 0x5A <= 0x01. When `pllPresent` was 0, no frame targets the reference buffer and the sequence has exactly five frames.
- R6: Every frame is a write (`frameRnw` = 0) with exactly one select bit set. `frameSel`, `frameAddr` and `frameData` hold steady while `frameReq` waits for `frameAck`, and `frameReq` drops in the cycle after the acknowledge.
- R7: No new frame is requested until `frameDone` has arrived after the acknowledge. A `frameDone` given in the same cycle as `frameAck` completes the frame. A `frameDone` given while no frame is acknowledged and pending is ignored.
- R8: `srcExternal` and `pllPresent` are sampled on the first clock edge after reset is released. Changing them afterwards does not alter the frames.
- R9: `bootHold` stays 1 until the last commit frame's `frameDone`. From the next cycle `bootHold` is 0 and `seqDone` is 1 until reset, and no further frame is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcExternal | input | 1 | 1 selects the external input of the sampling buffer |
| pllPresent | input | 1 | 1 when the external PLL module is fitted |
| frameReq | output | 1 | Frame request to the SPI master |
| frameAck | input | 1 | SPI master accepted the frame |
| frameDone | input | 1 | SPI master finished the accepted frame |
| frameSel | output | 2 | One-hot device select: bit 0 sampling buffer, bit 1 reference buffer |
| frameRnw | output | 1 | Read-not-write flag, always 0 |
| frameAddr | output | 8 | Register address |
| frameData | output | 8 | Register data |
| bootHold | output | 1 | Holds the processor in reset while 1 |
| seqDone | output | 1 | Sequence finished |

## Verification
Acceptance and completion of a frame can fall in the same cycle when the SPI master returns `frameDone` together with `frameAck`. The bench varies each frame's completion latency over zero, one and two cycles, so that same-cycle case occurs repeatedly within every run. It then checks that the next frame is neither skipped nor issued twice, and that it arrives with the correct contents. The bench also drives a stray `frameDone` while a request is still waiting for acknowledge, and again after the sequence has finished. It judges whether the frame order, the frame count, and the `seqDone`/`bootHold` levels stayed unaffected.

// File: rtl/clk_boot_pkg.sv
package clk_boot_pkg;

  localparam int REG_W = 8;
  localparam int SEL_W = 2;

  localparam logic [REG_W-1:0] REG_INPUT_SEL = 8'h45;
  localparam logic [REG_W-1:0] REG_OUT3_TYPE = 8'h40;
  localparam logic [REG_W-1:0] REG_OUT3_DIV  = 8'h50;
  localparam logic [REG_W-1:0] REG_OUT3_CTL  = 8'h51;
  localparam logic [REG_W-1:0] REG_OUT0_DIV  = 8'h4A;
  localparam logic [REG_W-1:0] REG_OUT0_CTL  = 8'h4B;
  localparam logic [REG_W-1:0] REG_COMMIT    = 8'h5A;

  localparam logic [REG_W-1:0] VAL_SRC_ONBOARD = 8'h05;
  localparam logic [REG_W-1:0] VAL_SRC_EXTERN  = 8'h02;
  localparam logic [REG_W-1:0] VAL_LVDS_ON     = 8'h02;
  localparam logic [REG_W-1:0] VAL_COMMIT      = 8'h01;

  localparam logic [SEL_W-1:0] SEL_SAMPLE = 2'b01;
  localparam logic [SEL_W-1:0] SEL_REF    = 2'b10;

  typedef enum logic [2:0] {
    ST_LATCH,
    ST_LOAD,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic latchOpts;
    logic loadEntry;
    logic advance;
  } seqStrobe_t;

  // Divider code: half-period minus one in both nibbles; ratio 1 gives 0.
  function automatic logic [REG_W-1:0] divCode(input int ratio);
    logic [3:0] half;
    if (ratio <= 1) return '0;
    half = 4'((ratio / 2) - 1);
    return {half, half};
  endfunction

  // Divider control: bit 7 bypasses the divider for ratio 1.
  function automatic logic [REG_W-1:0] divCtl(input int ratio);
    return (ratio <= 1) ? 8'h80 : 8'h00;
  endfunction

endpackage

// File: rtl/clk_boot_datapath.sv
module clk_boot_datapath
  import clk_boot_pkg::*;
#(
  parameter int FPGA_DIV = 1,
  parameter int REF_DIV  = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seqStrobe_t           strobe,
  input  logic                 srcExternal,
  input  logic                 pllPresent,
  output logic                 isLast,
  output logic [SEL_W-1:0]     frameSel,
  output logic                 frameRnw,
  output logic [REG_W-1:0]     frameAddr,
  output logic [REG_W-1:0]     frameData
);

  localparam int SAMP_LEN = 5;
  localparam int REF_LEN  = 4;
  localparam int TOTAL    = SAMP_LEN + REF_LEN;
  localparam int IDX_W    = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_SAMP = IDX_W'(SAMP_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_ALL  = IDX_W'(TOTAL - 1);
  localparam logic [REG_W-1:0] FPGA_CODE = divCode(FPGA_DIV);
  localparam logic [REG_W-1:0] FPGA_CTL  = divCtl(FPGA_DIV);
  localparam logic [REG_W-1:0] REF_CODE  = divCode(REF_DIV);
  localparam logic [REG_W-1:0] REF_CTL   = divCtl(REF_DIV);

  logic             optExt;
  logic             optPll;
  logic [IDX_W-1:0] entryIdx;
  logic [SEL_W-1:0] nextSel;
  logic [REG_W-1:0] nextAddr;
  logic [REG_W-1:0] nextData;

  // Write list, indexed by position.
  always_comb begin
    nextSel  = SEL_SAMPLE;
    nextAddr = REG_COMMIT;
    nextData = VAL_COMMIT;
    case (entryIdx)
      4'd0: begin
        nextAddr = REG_INPUT_SEL;
        nextData = optExt ? VAL_SRC_EXTERN : VAL_SRC_ONBOARD;
      end
      4'd1: begin nextAddr = REG_OUT3_TYPE; nextData = VAL_LVDS_ON; end
      4'd2: begin nextAddr = REG_OUT3_DIV;  nextData = FPGA_CODE;   end
      4'd3: begin nextAddr = REG_OUT3_CTL;  nextData = FPGA_CTL;    end
      4'd4: begin nextAddr = REG_COMMIT;    nextData = VAL_COMMIT;  end
      4'd5: begin
        nextSel  = SEL_REF;
        nextAddr = REG_INPUT_SEL;
        nextData = VAL_SRC_ONBOARD;
      end
      4'd6: begin nextSel = SEL_REF; nextAddr = REG_OUT0_DIV; nextData = REF_CODE; end
      4'd7: begin nextSel = SEL_REF; nextAddr = REG_OUT0_CTL; nextData = REF_CTL;  end
      default: begin nextSel = SEL_REF; nextAddr = REG_COMMIT; nextData = VAL_COMMIT; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      optExt    <= 1'b0;
      optPll    <= 1'b0;
      entryIdx  <= '0;
      frameSel  <= '0;
      frameAddr <= '0;
      frameData <= '0;
    end else begin
      if (strobe.latchOpts) begin
        optExt <= srcExternal;
        optPll <= pllPresent;
      end
      if (strobe.advance) entryIdx <= entryIdx + 1'b1;
      if (strobe.loadEntry) begin
        frameSel  <= nextSel;
        frameAddr <= nextAddr;
        frameData <= nextData;
      end
    end
  end

  assign frameRnw = 1'b0;
  assign isLast   = optPll ? (entryIdx == LAST_ALL) : (entryIdx == LAST_SAMP);

  // R8: options change only on the latch strobe
  assert_opts_held_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.latchOpts |=> $stable({optExt, optPll}));

  // R5: the list never runs past its end
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |-> (entryIdx < LAST_ALL));

endmodule

// File: rtl/clk_boot_ctrl.sv
module clk_boot_ctrl
  import clk_boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frameAck,
  input  logic       frameDone,
  input  logic       isLast,
  output seqStrobe_t strobe,
  output logic       frameReq,
  output logic       bootHold,
  output logic       seqDone
);

  seqState_t state;
  seqState_t stateNext;
  logic      entryDone;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    entryDone = 1'b0;
    case (state)
      ST_LATCH: begin
        strobe.latchOpts = 1'b1;
        stateNext        = ST_LOAD;
      end
      ST_LOAD: begin
        strobe.loadEntry = 1'b1;
        stateNext        = ST_REQ;
      end
      ST_REQ: begin
        if (frameAck) begin
          if (frameDone) entryDone = 1'b1;
          else           stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (frameDone) entryDone = 1'b1;
      end
      default: stateNext = ST_DONE;
    endcase
    if (entryDone) begin
      if (isLast) begin
        stateNext = ST_DONE;
      end else begin
        strobe.advance = 1'b1;
        stateNext      = ST_LOAD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_LATCH;
    else     state <= stateNext;
  end

  assign frameReq = (state == ST_REQ);
  assign bootHold = (state != ST_DONE);
  assign seqDone  = (state == ST_DONE);

  // R7: while waiting for completion no new request appears
  assert_no_req_in_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !frameDone) |=> !frameReq);

  // R9: finished state is kept until reset
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    seqDone |=> seqDone && !frameReq);

  // R6: request drops after acknowledge
  assert_req_drops_R6: assert property (@(posedge clk) disable iff (rst)
    (frameReq && frameAck) |=> !frameReq);

endmodule

// File: rtl/clk_boot_sequencer.sv
module clk_boot_sequencer
  import clk_boot_pkg::*;
#(
  parameter int FPGA_DIV = 1,
  parameter int REF_DIV  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srcExternal,
  input  logic             pllPresent,
  output logic             frameReq,
  input  logic             frameAck,
  input  logic             frameDone,
  output logic [SEL_W-1:0] frameSel,
  output logic             frameRnw,
  output logic [REG_W-1:0] frameAddr,
  output logic [REG_W-1:0] frameData,
  output logic             bootHold,
  output logic             seqDone
);

  seqStrobe_t strobe;
  logic       isLast;

  clk_boot_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .frameAck  (frameAck),
    .frameDone (frameDone),
    .isLast    (isLast),
    .strobe    (strobe),
    .frameReq  (frameReq),
    .bootHold  (bootHold),
    .seqDone   (seqDone)
  );

  clk_boot_datapath #(
    .FPGA_DIV (FPGA_DIV),
    .REF_DIV  (REF_DIV)
  ) u_data (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .srcExternal (srcExternal),
    .pllPresent  (pllPresent),
    .isLast      (isLast),
    .frameSel    (frameSel),
    .frameRnw    (frameRnw),
    .frameAddr   (frameAddr),
    .frameData   (frameData)
  );

  // R6: frame contents steady while awaiting acknowledge
  assert_frame_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (frameReq && !frameAck) |=> frameReq && $stable({frameSel, frameAddr, frameData}));

  // R6: exactly one device selected on every request
  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    frameReq |-> ($countones(frameSel) == 1));

  // R4: completion follows a commit frame
  assert_ends_commit_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(seqDone) |-> (frameAddr == REG_COMMIT) && (frameData == VAL_COMMIT));

  // R9: completion is caused by a frame finishing
  assert_done_after_frame_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(seqDone) |-> $past(frameDone));

endmodule

// File: tb/test_clk_boot_sequencer.sv
module test_clk_boot_sequencer;

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] addr;
    logic [7:0] data;
  } frm_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       srcExternal = 1'b0;
  logic       pllPresent = 1'b0;
  logic       frameReq;
  logic       frameAck = 1'b0;
  logic       frameDone = 1'b0;
  logic [1:0] frameSel;
  logic       frameRnw;
  logic [7:0] frameAddr;
  logic [7:0] frameData;
  logic       bootHold;
  logic       seqDone;

  int   checks = 0;
  int   fails = 0;
  frm_t expQ[$];
  int   frameNum = 0;
  int   waitCnt = 0;
  logic stallFirst = 1'b0;
  logic injectDone = 1'b0;
  logic reqSeen = 1'b0;

  always #4 clk = ~clk;

  clk_boot_sequencer i_clk_boot_sequencer (
    .clk (clk), .rst (rst), .srcExternal (srcExternal), .pllPresent (pllPresent),
    .frameReq (frameReq), .frameAck (frameAck), .frameDone (frameDone),
    .frameSel (frameSel), .frameRnw (frameRnw), .frameAddr (frameAddr),
    .frameData (frameData), .bootHold (bootHold), .seqDone (seqDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic string tagOf(input frm_t f);
    if (f.sel == 2'b10)   return "R5";
    if (f.addr == 8'h45)  return "R2";
    if (f.addr == 8'h5A)  return "R4";
    return "R3";
  endfunction

  // Monitor and SPI master model, acting on the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      frameAck  = 1'b0;
      frameDone = 1'b0;
      if (rst) begin
        waitCnt = 0;
        reqSeen = 1'b0;
      end else if (waitCnt > 0) begin
        check(!frameReq, "R7", "request while frame pending", frameReq, 0);
        waitCnt--;
        if (waitCnt == 0) frameDone = 1'b1;
      end else if (frameReq) begin
        if (stallFirst) begin
          stallFirst = 1'b0;
          frameDone  = 1'b1;   // stray completion before acknowledge (R7)
        end else begin
          frm_t got;
          frm_t exp;
          got = '{sel: frameSel, addr: frameAddr, data: frameData};
          check(bootHold, "R9", "bootHold during frames", bootHold, 1);
          check(!frameRnw, "R6", "frame direction", frameRnw, 0);
          if (expQ.size() == 0) begin
            check(1'b0, "R5", "unexpected frame", got, 0);
          end else begin
            exp = expQ.pop_front();
            check(got == exp, tagOf(exp), "frame {sel,addr,data}", got, exp);
          end
          frameAck = 1'b1;
          if ((frameNum % 3) == 0) frameDone = 1'b1;   // same-cycle completion
          else waitCnt = frameNum % 3;
          frameNum++;
        end
      end else if (injectDone) begin
        frameDone = 1'b1;
      end
    end
  end

  task automatic pushCase(input bit ext, input bit pll);
    expQ.push_back('{sel: 2'b01, addr: 8'h45, data: ext ? 8'h02 : 8'h05});
    expQ.push_back('{sel: 2'b01, addr: 8'h40, data: 8'h02});
    expQ.push_back('{sel: 2'b01, addr: 8'h50, data: 8'h00});
    expQ.push_back('{sel: 2'b01, addr: 8'h51, data: 8'h80});
    expQ.push_back('{sel: 2'b01, addr: 8'h5A, data: 8'h01});
    if (pll) begin
      expQ.push_back('{sel: 2'b10, addr: 8'h45, data: 8'h05});
      expQ.push_back('{sel: 2'b10, addr: 8'h4A, data: 8'h33});
      expQ.push_back('{sel: 2'b10, addr: 8'h4B, data: 8'h00});
      expQ.push_back('{sel: 2'b10, addr: 8'h5A, data: 8'h01});
    end
  endtask

  task automatic runCase(input bit ext, input bit pll, input bit stall);
    int waited;
    @(negedge clk);
    rst = 1'b1;
    srcExternal = ext;
    pllPresent = pll;
    repeat (3) @(negedge clk);
    check(bootHold && !seqDone && !frameReq, "R1", "reset outputs {hold,done,req}",
          {bootHold, seqDone, frameReq}, 3'b100);
    expQ.delete();
    pushCase(ext, pll);
    stallFirst = stall;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    srcExternal = ~ext;      // R8: late change must not matter
    pllPresent  = ~pll;
    waited = 0;
    while (!seqDone && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    check(seqDone, "R9", "seqDone after last commit", seqDone, 1);
    check(!bootHold, "R9", "bootHold released", bootHold, 0);
    check(expQ.size() == 0, "R8", "frames left unsent", expQ.size(), 0);
    injectDone = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (frameReq) check(1'b0, "R9", "request after done", frameReq, 0);
    end
    injectDone = 1'b0;
    check(seqDone && !bootHold, "R7", "stray done after finish {done,hold}",
          {seqDone, bootHold}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    runCase(1'b0, 1'b0, 1'b0);
    runCase(1'b1, 1'b0, 1'b1);
    runCase(1'b0, 1'b1, 1'b1);
    runCase(1'b1, 1'b1, 1'b0);
    runCase(1'b1, 1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule